// File: doc/BRIEF.md
# Two-Way Set-Associative CPU Cache

This block sits between one CPU and a slow external memory. It answers word reads and writes from an internal store of 512 sets, each holding two 32-byte lines. A read that finds no matching line fetches the whole line from external memory, one 32-bit word at a time, over a request/ready handshake. The requested word goes back to the CPU after the last word of that line has arrived. A write that finds its line updates the cached copy only. A write that misses is passed to memory as a single word, and no line is allocated for it.

An enable input switches the cache on or off. While it is off, every CPU access becomes a single-word external access, and the tag and data store are neither read nor changed. A flush is armed by a rising edge on the flush control. The flush walks through all sets, one per clock, and marks every line empty. Lines that the CPU has modified are dropped, and nothing is written back to memory. While the flush runs, a busy output is high and CPU requests wait.

The CPU raises `cpuReq` and holds it, together with its address, write flag and write data, until it sees a one-cycle `cpuReady` pulse. Each CPU address is split into three parts: bits 4:0 are the byte within the line, bits 13:5 select the set, and bits 31:14 form the tag.

Top module: `twoway_cache`

## Requirements
- R1: After reset, `cpuReady`, `memReq` and `busy` are low and every line is empty, so the first read of any address misses.
- R2: A read miss holds `memReq` high with a stable `memAddr` until `memReady`, once for each of the 8 words. `cpuReady` then pulses for exactly one cycle, and `cpuRdata` carries the word at the requested address, even when that word is not the first word of the line.
- R3: During a line fill, the external read addresses run upward in steps of 4 from the line base, which is the CPU address with bits 4:0 cleared.
- R4: A read hit makes no external request, and `cpuReady` is high in the clock after the request is first seen.
- R5: A write hit changes the cached word and makes no external write. A later read hit returns the new value.
- R6: A write miss makes exactly one external write (`memWe`=1) of `cpuWdata` to the CPU address and allocates no line. A later read of that address misses and fills the line from memory.
- R7: Each set holds two lines with different tags. A per-set bit names the way to fill next. Every hit or fill sets this bit to the other way, so a miss replaces the way that was used less recently.
- R8: While `cacheEn` is low, each access is a single external word access: a read returns memory data, and a write goes to memory. Cached contents are neither returned nor changed, and they are still present after `cacheEn` returns high.
- R9: A 0-to-1 transition of `flushEn` starts a flush. `busy` then stays high for at least 512 cycles, and no external request or `cpuReady` occurs while sets are being cleared. A CPU request made during the flush completes after it.
- R10: After a flush every line is empty. Modified cached data is lost, no external write takes place, and a read returns the memory value.
- R11: Holding `flushEn` high, or driving it from 1 to 0, starts no flush. At reset `flushEn` counts as previously high, so a clear is required first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cacheEn | input | 1 | Cache on when high |
| flushEn | input | 1 | Flush control; a rising edge starts a flush |
| cpuReq | input | 1 | CPU access request, held until `cpuReady` |
| cpuWe | input | 1 | 1 for a write, 0 for a read |
| cpuAddr | input | 32 | CPU byte address |
| cpuWdata | input | 32 | CPU write data |
| cpuRdata | output | 32 | Read data, valid while `cpuReady` is high |
| cpuReady | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Flush pending or in progress |
| memReq | output | 1 | External access request |
| memWe | output | 1 | External write when high |
| memAddr | output | 32 | External byte address |
| memWdata | output | 32 | External write data |
| memRdata | input | 32 | External read data |
| memReady | input | 1 | External access completes this cycle |

## Verification
The lookup is tested with three tags that map to one set. This separates a correct replacement choice from a fixed victim or a victim that ignores recent hits. Misses request a word in the middle of a line, which exposes a design that returns the first fetched word or fills in a wrong order. Reads, write hits and write misses are each run with the cache both on and off. The external read and write counts, together with the returned data, show whether the cached copy, the memory copy or neither was touched. Flush is tested by a clean rising edge, by a request made while busy, and by holding or dropping the control.

// File: rtl/twc_pkg.sv
package twc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RESP,
    ST_FILL,
    ST_SINGLE,
    ST_FLUSH
  } ctlState_e;

  // Strobes from the controller to the datapath
  typedef struct packed {
    logic hitRead;     // latch hit word, touch replacement bit
    logic hitWrite;    // patch word in hit way, touch replacement bit
    logic fillActive;  // external address comes from the fill counter
    logic fillStep;    // one fill word accepted
    logic fillDone;    // last fill word: commit line, tag, valid
    logic singleDone;  // single external access finished
    logic flushStep;   // clear one set
  } ctlStrobe_t;

endpackage

// File: rtl/twc_ctrl.sv
module twc_ctrl
  import twc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cacheEn,
  input  logic       flushEn,
  input  logic       cpuReq,
  input  logic       cpuWe,
  input  logic       hit,
  input  logic       fillLast,
  input  logic       flushLast,
  input  logic       memReady,
  output ctlStrobe_t ctl,
  output logic       cpuReady,
  output logic       memReq,
  output logic       memWe,
  output logic       busy
);

  ctlState_e state, stateNext;
  logic flushPrev, flushPend;
  logic flushRise;

  assign flushRise = flushEn & ~flushPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      flushPrev <= 1'b1;
      flushPend <= 1'b0;
    end else begin
      state     <= stateNext;
      flushPrev <= flushEn;
      if (flushRise)
        flushPend <= 1'b1;
      else if (stateNext == ST_FLUSH && state != ST_FLUSH)
        flushPend <= 1'b0;
    end
  end

  always_comb begin
    stateNext = state;
    ctl       = '0;
    unique case (state)
      ST_IDLE: begin
        if (flushPend) begin
          stateNext = ST_FLUSH;
        end else if (cpuReq) begin
          if (!cacheEn) begin
            stateNext = ST_SINGLE;
          end else if (hit) begin
            stateNext    = ST_RESP;
            ctl.hitRead  = ~cpuWe;
            ctl.hitWrite = cpuWe;
          end else if (cpuWe) begin
            stateNext = ST_SINGLE;
          end else begin
            stateNext = ST_FILL;
          end
        end
      end
      ST_FILL: begin
        ctl.fillActive = 1'b1;
        if (memReady) begin
          ctl.fillStep = 1'b1;
          if (fillLast) begin
            ctl.fillDone = 1'b1;
            stateNext    = ST_RESP;
          end
        end
      end
      ST_SINGLE: begin
        if (memReady) begin
          ctl.singleDone = 1'b1;
          stateNext      = ST_RESP;
        end
      end
      ST_RESP: stateNext = ST_IDLE;
      ST_FLUSH: begin
        ctl.flushStep = 1'b1;
        if (flushLast) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign cpuReady = (state == ST_RESP);
  assign memReq   = (state == ST_FILL) || (state == ST_SINGLE);
  assign memWe    = (state == ST_SINGLE) && cpuWe;
  assign busy     = flushPend || (state == ST_FLUSH);

endmodule

// File: rtl/twc_datapath.sv
module twc_datapath
  import twc_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int SETS       = 512,
  parameter int WAYS       = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        ctl,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  input  logic [DATA_W-1:0] memRdata,
  output logic              hit,
  output logic              fillLast,
  output logic              flushLast,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] cpuRdata
);

  localparam int WORD_BYTES = DATA_W / 8;
  localparam int WORDS      = LINE_BYTES / WORD_BYTES;
  localparam int LINE_W     = LINE_BYTES * 8;
  localparam int OFF_W      = $clog2(LINE_BYTES);
  localparam int BSEL_W     = $clog2(WORD_BYTES);
  localparam int WSEL_W     = $clog2(WORDS);
  localparam int IDX_W      = $clog2(SETS);
  localparam int TAG_W      = ADDR_W - IDX_W - OFF_W;

  logic [TAG_W-1:0]  addrTag;
  logic [IDX_W-1:0]  addrIdx;
  logic [WSEL_W-1:0] addrWord;

  assign addrTag  = cpuAddr[ADDR_W-1 -: TAG_W];
  assign addrIdx  = cpuAddr[OFF_W +: IDX_W];
  assign addrWord = cpuAddr[BSEL_W +: WSEL_W];

  logic [WAYS-1:0]   wayHit;
  logic [LINE_W-1:0] wayLine [WAYS];
  logic              hitWay;
  logic              victim;
  logic [SETS-1:0]   lruBits;
  logic [IDX_W-1:0]  flushIdx;

  // fill assembly
  logic [LINE_W-1:0] fillBuf, fillLine;
  logic [WSEL_W-1:0] fillCnt;

  always_comb begin
    fillLine = fillBuf;
    fillLine[fillCnt*DATA_W +: DATA_W] = memRdata;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fillBuf <= '0;
      fillCnt <= '0;
    end else if (ctl.fillStep) begin
      fillBuf <= fillLine;
      fillCnt <= fillCnt + 1'b1;
    end
  end

  assign fillLast = (fillCnt == WSEL_W'(WORDS - 1));
  assign victim   = lruBits[addrIdx];

  genvar w;
  generate
    for (w = 0; w < WAYS; w++) begin : gen_way
      logic [LINE_W-1:0] lineMem [SETS];
      logic [TAG_W-1:0]  tagMem  [SETS];
      logic [SETS-1:0]   validBits;
      logic [LINE_W-1:0] patched;
      logic              isVictim;
      logic              doPatch;

      assign isVictim  = (victim == w[0]);
      assign doPatch   = ctl.hitWrite && wayHit[w];
      assign wayHit[w] = validBits[addrIdx] && (tagMem[addrIdx] == addrTag);
      assign wayLine[w] = lineMem[addrIdx];

      always_comb begin
        patched = lineMem[addrIdx];
        patched[addrWord*DATA_W +: DATA_W] = cpuWdata;
      end

      always_ff @(posedge clk) begin
        if (ctl.fillDone && isVictim) begin
          lineMem[addrIdx] <= fillLine;
          tagMem[addrIdx]  <= addrTag;
        end else if (doPatch) begin
          lineMem[addrIdx] <= patched;
        end
      end

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)
          validBits <= '0;
        else if (ctl.flushStep)
          validBits[flushIdx] <= 1'b0;
        else if (ctl.fillDone && isVictim)
          validBits[addrIdx] <= 1'b1;
      end
    end
  endgenerate

  assign hit    = |wayHit;
  assign hitWay = wayHit[1];

  // replacement bit: names the way to fill next
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      lruBits <= '0;
    else if (ctl.flushStep)
      lruBits[flushIdx] <= 1'b0;
    else if (ctl.hitRead || ctl.hitWrite)
      lruBits[addrIdx] <= ~hitWay;
    else if (ctl.fillDone)
      lruBits[addrIdx] <= ~victim;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      flushIdx <= '0;
    else if (ctl.flushStep)
      flushIdx <= flushIdx + 1'b1;
  end

  assign flushLast = (flushIdx == IDX_W'(SETS - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      cpuRdata <= '0;
    else if (ctl.hitRead)
      cpuRdata <= wayLine[hitWay][addrWord*DATA_W +: DATA_W];
    else if (ctl.fillDone)
      cpuRdata <= fillLine[addrWord*DATA_W +: DATA_W];
    else if (ctl.singleDone)
      cpuRdata <= memRdata;
  end

  assign memAddr = ctl.fillActive ? {addrTag, addrIdx, fillCnt, {BSEL_W{1'b0}}} : cpuAddr;

endmodule

// File: rtl/twoway_cache.sv
module twoway_cache
  import twc_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int SETS       = 512
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cacheEn,
  input  logic              flushEn,
  input  logic              cpuReq,
  input  logic              cpuWe,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  output logic [DATA_W-1:0] cpuRdata,
  output logic              cpuReady,
  output logic              busy,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  input  logic              memReady
);

  ctlStrobe_t ctl;
  logic hit, fillLast, flushLast;

  twc_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cacheEn  (cacheEn),
    .flushEn  (flushEn),
    .cpuReq   (cpuReq),
    .cpuWe    (cpuWe),
    .hit      (hit),
    .fillLast (fillLast),
    .flushLast(flushLast),
    .memReady (memReady),
    .ctl      (ctl),
    .cpuReady (cpuReady),
    .memReq   (memReq),
    .memWe    (memWe),
    .busy     (busy)
  );

  twc_datapath #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .LINE_BYTES(LINE_BYTES),
    .SETS      (SETS),
    .WAYS      (2)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .cpuAddr  (cpuAddr),
    .cpuWdata (cpuWdata),
    .memRdata (memRdata),
    .hit      (hit),
    .fillLast (fillLast),
    .flushLast(flushLast),
    .memAddr  (memAddr),
    .cpuRdata (cpuRdata)
  );

  assign memWdata = cpuWdata;

endmodule

// File: rtl/twoway_cache_chk.sv
module twoway_cache_chk
  import twc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input ctlStrobe_t        ctl,
  input logic              cpuReady,
  input logic              cpuWe,
  input logic              memReq,
  input logic              memWe,
  input logic              memReady,
  input logic [ADDR_W-1:0] memAddr
);

  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(DATA_W / 8);

  // R3
  fill_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.fillStep && !ctl.fillDone) |=> (memReq && memAddr == $past(memAddr) + STEP));

  // R2
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memReady) |=> (memReq && $stable(memAddr) && $stable(memWe)));

  // R2
  ready_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    cpuReady |=> !cpuReady);

  // R9
  flush_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.flushStep |-> (!memReq && !cpuReady));

  // R6
  mem_write_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWe) |-> cpuWe);

  // R4
  hit_no_mem_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.hitRead || ctl.hitWrite) |-> !memReq);

  // R2
  fill_uses_port_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.fillActive || ctl.singleDone) |-> memReq);

endmodule

bind twoway_cache twoway_cache_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .ctl     (ctl),
  .cpuReady(cpuReady),
  .cpuWe   (cpuWe),
  .memReq  (memReq),
  .memWe   (memWe),
  .memReady(memReady),
  .memAddr (memAddr)
);

// File: tb/twoway_cache_test.sv
module twoway_cache_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cacheEn = 1'b1;
  logic        flushEn = 1'b0;
  logic        cpuReq = 1'b0;
  logic        cpuWe = 1'b0;
  logic [31:0] cpuAddr = '0;
  logic [31:0] cpuWdata = '0;
  logic [31:0] cpuRdata;
  logic        cpuReady, busy, memReq, memWe;
  logic [31:0] memAddr, memWdata;
  logic [31:0] memRdata = '0;
  logic        memReady = 1'b0;

  int checks = 0;
  int fails = 0;
  int memReads = 0;
  int memWrites = 0;
  int waitCnt = 0;
  logic [31:0] readLog [64];
  logic [31:0] wmem [logic [31:0]];

  always #(CLK_PERIOD/2) clk = ~clk;

  twoway_cache uut (
    .clk(clk), .rstN(rstN), .cacheEn(cacheEn), .flushEn(flushEn),
    .cpuReq(cpuReq), .cpuWe(cpuWe), .cpuAddr(cpuAddr), .cpuWdata(cpuWdata),
    .cpuRdata(cpuRdata), .cpuReady(cpuReady), .busy(busy),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .memReady(memReady)
  );

  function automatic logic [31:0] memVal(input logic [31:0] a);
    if (wmem.exists(a)) return wmem[a];
    return (a * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
  endfunction

  // external memory model, two-cycle latency, acts on falling edges
  always @(negedge clk) begin
    if (!memReq || memReady) begin
      memReady = 1'b0;
      waitCnt  = 0;
    end else if (waitCnt == 1) begin
      memReady = 1'b1;
      if (memWe) begin
        wmem[memAddr] = memWdata;
        memWrites = memWrites + 1;
      end else begin
        memRdata = memVal(memAddr);
        readLog[memReads % 64] = memAddr;
        memReads = memReads + 1;
      end
    end else begin
      waitCnt = waitCnt + 1;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic access(input logic we, input logic [31:0] addr, input logic [31:0] wd,
                        output logic [31:0] rd, output int cyc);
    @(negedge clk);
    cpuReq = 1'b1; cpuWe = we; cpuAddr = addr; cpuWdata = wd;
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!cpuReady && cyc < 5000);
    rd = cpuRdata;
    cpuReq = 1'b0; cpuWe = 1'b0;
  endtask

  localparam logic [31:0] A = 32'h0001_0040;  // set 2, tag 4
  localparam logic [31:0] B = A + 32'h4000;   // same set, tag 5
  localparam logic [31:0] C = A + 32'h8000;   // same set, tag 6
  localparam logic [31:0] D = 32'h0002_0100;
  localparam logic [31:0] W1 = 32'hC0DE_0001;
  localparam logic [31:0] W2 = 32'hC0DE_0002;

  logic [31:0] origA8, origA12;

  task automatic testReset();
    check("R1 cpuReady", {31'b0, cpuReady}, 32'd0);
    check("R1 memReq", {31'b0, memReq}, 32'd0);
    check("R1 busy", {31'b0, busy}, 32'd0);
  endtask

  task automatic testReadMiss();
    logic [31:0] rd; int cyc; int r0;
    r0 = memReads;
    origA8  = memVal(A + 8);
    origA12 = memVal(A + 12);
    access(1'b0, A + 32'h14, '0, rd, cyc);
    check("R2 miss data", rd, memVal(A + 32'h14));
    check("R2 fill count", memReads - r0, 8);
    for (int i = 0; i < 8; i++)
      check("R3 fill address", readLog[(r0 + i) % 64], A + 32'(4 * i));
  endtask

  task automatic testReadHit();
    logic [31:0] rd; int cyc; int r0;
    r0 = memReads;
    access(1'b0, A + 4, '0, rd, cyc);
    check("R4 hit data", rd, memVal(A + 4));
    check("R4 hit latency", cyc, 1);
    check("R4 no external read", memReads - r0, 0);
  endtask

  task automatic testWriteHit();
    logic [31:0] rd; int cyc; int w0;
    w0 = memWrites;
    access(1'b1, A + 8, W1, rd, cyc);
    access(1'b0, A + 8, '0, rd, cyc);
    check("R5 write hit readback", rd, W1);
    check("R5 no external write", memWrites - w0, 0);
  endtask

  task automatic testWriteMiss();
    logic [31:0] rd; int cyc; int w0; int r0;
    w0 = memWrites; r0 = memReads;
    access(1'b1, D, 32'hDEAD_BEEF, rd, cyc);
    check("R6 one external write", memWrites - w0, 1);
    check("R6 no fill on write", memReads - r0, 0);
    check("R6 memory holds data", memVal(D), 32'hDEAD_BEEF);
    r0 = memReads;
    access(1'b0, D, '0, rd, cyc);
    check("R6 read after write miss", rd, 32'hDEAD_BEEF);
    check("R6 no allocation", memReads - r0, 8);
  endtask

  task automatic testWays();
    logic [31:0] rd; int cyc; int r0;
    r0 = memReads; access(1'b0, B, '0, rd, cyc);
    check("R7 B misses", memReads - r0, 8);
    r0 = memReads; access(1'b0, A, '0, rd, cyc);
    check("R7 A still held", memReads - r0, 0);
    check("R7 A data", rd, memVal(A));
    r0 = memReads; access(1'b0, C, '0, rd, cyc);
    check("R7 C misses", memReads - r0, 8);
    r0 = memReads; access(1'b0, A + 8, '0, rd, cyc);
    check("R7 A kept over B", memReads - r0, 0);
    check("R7 A modified word", rd, W1);
    r0 = memReads; access(1'b0, B, '0, rd, cyc);
    check("R7 B was evicted", memReads - r0, 8);
    check("R7 B data", rd, memVal(B));
  endtask

  task automatic testDisabled();
    logic [31:0] rd; int cyc; int r0; int w0;
    cacheEn = 1'b0;
    r0 = memReads;
    access(1'b0, A + 8, '0, rd, cyc);
    check("R8 bypass read data", rd, origA8);
    check("R8 bypass single read", memReads - r0, 1);
    w0 = memWrites;
    access(1'b1, A + 12, W2, rd, cyc);
    check("R8 bypass write", memWrites - w0, 1);
    cacheEn = 1'b1;
    r0 = memReads;
    access(1'b0, A + 8, '0, rd, cyc);
    check("R8 cached word kept", rd, W1);
    access(1'b0, A + 12, '0, rd, cyc);
    check("R8 cached word unchanged", rd, origA12);
    check("R8 no reads after reenable", memReads - r0, 0);
  endtask

  task automatic testFlush();
    logic [31:0] rd; int cyc; int w0; int r0; int n;
    w0 = memWrites;
    @(negedge clk); flushEn = 1'b1;
    @(negedge clk);
    n = 0;
    while (busy && n < 2000) begin
      n++;
      @(negedge clk);
    end
    check("R9 busy length ok", {31'b0, (n >= 512 && n <= 520)}, 32'd1);
    check("R10 no write-back", memWrites - w0, 0);
    r0 = memReads;
    access(1'b0, A + 8, '0, rd, cyc);
    check("R10 modified data dropped", rd, origA8);
    check("R10 line refetched", memReads - r0, 8);
    // a request made during a flush waits for it
    @(negedge clk); flushEn = 1'b0;
    @(negedge clk); flushEn = 1'b1;
    access(1'b0, A + 8, '0, rd, cyc);
    check("R9 request stalled", {31'b0, (cyc > 512)}, 32'd1);
    check("R9 stalled read data", rd, origA8);
  endtask

  task automatic testFlushLevel();
    logic [31:0] rd; int cyc; int r0; int seen;
    seen = 0;
    r0 = memReads;
    access(1'b0, A + 8, '0, rd, cyc);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (busy) seen++;
    end
    flushEn = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (busy) seen++;
    end
    check("R11 no flush on level or fall", seen, 0);
    access(1'b0, A + 8, '0, rd, cyc);
    check("R11 line survives", memReads - r0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testReadMiss();
    testReadHit();
    testWriteHit();
    testWriteMiss();
    testWays();
    testDisabled();
    testFlush();
    testFlushLevel();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule